// File: doc/BRIEF.md
# Fractional-Rate Precision Time Counter

This block keeps a free-running 64-bit system time for a precision time protocol node. The count does not move by a fixed step. Each clock, a 32-bit rate word is added into a 32-bit fractional accumulator, and every carry out of that sum moves the time forward by one tick. One tick stands for 16 ns, so software turns ticks into nanoseconds with a left shift of four. Software trims the clock frequency by changing the rate word.

A 32-bit register port gives software access to these registers:

- control
- event
- rate word
- accumulator
- system time, as low and high words
- target time, as low and high words

The 64-bit time is split across two words, and both words are kept coherent:

- A read of the low word captures the high word at the same instant, and a later read of the high word returns that captured copy.
- A write to the low word is only staged. The following write to the high word loads all 64 bits at once.

When target mode is on and the time has reached the programmed target, a sticky pending flag is set. Writing 1 to that flag clears it.

Top module: `ptp_sys_timer`

## Requirements
- R1: After reset the rate word reads 0xF0000029, and the control, event, accumulator and time registers read 0.
- R2: Each clock while running, the accumulator becomes (accumulator + rate word) mod 2^32. When that sum carries out of bit 31, the system time increases by exactly 1. Starting from a zero accumulator and zero time, after k running clocks the time is floor(k·A/2^32) and the accumulator is (k·A) mod 2^32, where A is the rate word.
- R3: While control bit 0 (hold) is 1, the system time and the accumulator are held at 0.
- R4: Reading the time low word (offset 0x20) captures the high word. A later read of the high word (offset 0x24) returns that captured value, even if the live time has since carried into the high word.
- R5: A write to the time low word alone does not change the time. A write to the time high word loads {written high word, last written low word} as the new time.
- R6: When control bit 1 (target enable) is 1 and the time is greater than or equal to the 64-bit target, event bit 1 becomes 1 and the `tgt_pending` output becomes 1.
- R7: Writing an event word with bit 1 set clears the pending flag, unless the set condition of R6 still holds in that cycle; the set wins. Writing 0 to the event register leaves the flag unchanged.
- R8: While target enable is 0, a clear pending flag stays 0, whatever the time and target are.
- R9: Register offsets are as follows. A read issued in one cycle returns its data with `reg_rdata_valid` one cycle later.

  | Offset | Register |
  |---|---|
  | 0x00 | control |
  | 0x04 | event |
  | 0x08 | rate word |
  | 0x0C | accumulator |
  | 0x20 | time low word |
  | 0x24 | time high word |
  | 0x28 | target low word |
  | 0x2C | target high word |

  The control register reads back with hold in bit 0 and target enable in bit 1. The target words read back as written.
- R10: A write to the accumulator replaces its value, and no carry is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rdata_valid | output | 1 | Read data valid, one cycle after the read strobe |
| tgt_pending | output | 1 | Sticky target-reached flag |

## Verification
Timing of each result:

- A register write takes effect at the clock edge that samples it.
- Read data is registered, so it appears one cycle after the read strobe. It reflects register state as it was just before that edge.
- The time and the accumulator first advance on the edge after hold is released.
- The pending flag follows the time compare one edge later.

How the checks keep to that timing:

- The driver notes the index of the edge on which each write and read lands.
- For time and accumulator reads, the driver computes floor(k·A/2^32) and (k·A) mod 2^32 from the exact number k of running edges before the read. It pushes that value into the scoreboard queue, and the monitor pops it when the valid strobe appears.
- The pending output is checked only after several settling cycles, so the one-edge compare delay never sits on a sample point.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
    localparam int REG_AW = 8;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_EVENT   = 8'h04;
    localparam logic [REG_AW-1:0] OFS_ADDEND  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_ACCUM   = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_TIME_LO = 8'h20;
    localparam logic [REG_AW-1:0] OFS_TIME_HI = 8'h24;
    localparam logic [REG_AW-1:0] OFS_TGT_LO  = 8'h28;
    localparam logic [REG_AW-1:0] OFS_TGT_HI  = 8'h2C;
    localparam int CTRL_HOLD_BIT   = 0;
    localparam int CTRL_TGT_EN_BIT = 1;
    localparam int EVT_TGT_BIT     = 1;
endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
    parameter int ACC_W = 32,
    parameter logic [ACC_W-1:0] ADDEND_RST = 32'hF0000029
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             addend_we,
    input  logic             accum_we,
    input  logic [ACC_W-1:0] wdata,
    output logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] accum,
    output logic             tick
);
    typedef struct packed {
        logic [ACC_W-1:0] addend;
        logic [ACC_W-1:0] accum;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W:0] sum_full;

    always_comb begin
        st_d     = st_q;
        sum_full = {1'b0, st_q.accum} + {1'b0, st_q.addend};
        tick     = 1'b0;
        if (addend_we) st_d.addend = wdata;
        if (hold) begin
            st_d.accum = '0;
        end else if (accum_we) begin
            st_d.accum = wdata;
        end else begin
            st_d.accum = sum_full[ACC_W-1:0];
            tick       = sum_full[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addend <= ADDEND_RST;
            st_q.accum  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addend = st_q.addend;
    assign accum  = st_q.accum;

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !accum_we) |=> accum == ACC_W'($past(accum) + $past(addend))) // R2
        else $error("accumulator step wrong");
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> accum == '0) // R3
        else $error("accumulator not held");
    AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && accum_we) |=> accum == $past(wdata)) // R10
        else $error("accumulator load wrong");
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core #(
    parameter int WORD_W = 32,
    localparam int TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tick,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              lo_rd,
    input  logic [WORD_W-1:0] wdata,
    output logic [TIME_W-1:0] sys_time,
    output logic [WORD_W-1:0] hi_shadow
);
    typedef struct packed {
        logic [TIME_W-1:0] tval;
        logic [WORD_W-1:0] lo_stage;
        logic [WORD_W-1:0] hi_cap;
    } time_st_t;

    time_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we) st_d.lo_stage = wdata;
        if (lo_rd) st_d.hi_cap = st_q.tval[TIME_W-1:WORD_W];
        if (hold) begin
            st_d.tval = '0;
        end else if (hi_we) begin
            st_d.tval = {wdata, st_q.lo_stage};
        end else if (tick) begin
            st_d.tval = st_q.tval + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sys_time  = st_q.tval;
    assign hi_shadow = st_q.hi_cap;

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !hi_we) |=> sys_time == $past(sys_time) + TIME_W'($past(tick))) // R2
        else $error("time step wrong");
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> sys_time == '0) // R3
        else $error("time not held");
    AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && hi_we && !lo_we) |=> sys_time == {$past(wdata), $past(st_q.lo_stage)}) // R5
        else $error("time load wrong");
    AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd |=> $stable(hi_shadow)) // R4
        else $error("captured high word moved");
endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp #(
    parameter int WORD_W = 32,
    localparam int TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              enable,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              clr,
    input  logic [WORD_W-1:0] wdata,
    output logic [TIME_W-1:0] target,
    output logic              pending
);
    typedef struct packed {
        logic [TIME_W-1:0] tgt;
        logic              pend;
    } tgt_st_t;

    tgt_st_t st_d, st_q;
    logic    reached;

    always_comb begin
        st_d    = st_q;
        reached = enable && (sys_time >= st_q.tgt);
        if (lo_we) st_d.tgt[WORD_W-1:0]      = wdata;
        if (hi_we) st_d.tgt[TIME_W-1:WORD_W] = wdata;
        st_d.pend = reached || (st_q.pend && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign target  = st_q.tgt;
    assign pending = st_q.pend;

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sys_time >= target) |=> pending) // R6
        else $error("pending not set");
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !enable) |=> !pending) // R7
        else $error("pending not cleared");
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !pending) |=> !pending) // R8
        else $error("pending set while disabled");
endmodule

// File: rtl/ptp_sys_timer.sv
module ptp_sys_timer
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = REG_AW,
    parameter logic [DATA_W-1:0] ADDEND_RST = 32'hF0000029
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rdata_valid,
    output logic              tgt_pending
);
    localparam int TIME_W = 2 * DATA_W;

    typedef struct packed {
        logic              hold;
        logic              tgt_en;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [DATA_W-1:0] addend, accum, hi_shadow;
    logic [TIME_W-1:0] sys_time, target;
    logic              tick, pending;

    logic hit_ctrl, hit_evt, hit_add, hit_acc, hit_tlo, hit_thi, hit_glo, hit_ghi;
    assign hit_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
    assign hit_evt  = reg_addr == ADDR_W'(OFS_EVENT);
    assign hit_add  = reg_addr == ADDR_W'(OFS_ADDEND);
    assign hit_acc  = reg_addr == ADDR_W'(OFS_ACCUM);
    assign hit_tlo  = reg_addr == ADDR_W'(OFS_TIME_LO);
    assign hit_thi  = reg_addr == ADDR_W'(OFS_TIME_HI);
    assign hit_glo  = reg_addr == ADDR_W'(OFS_TGT_LO);
    assign hit_ghi  = reg_addr == ADDR_W'(OFS_TGT_HI);

    ptp_rate_accum #(.ACC_W(DATA_W), .ADDEND_RST(ADDEND_RST)) i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (st_q.hold),
        .addend_we (reg_wr_en && hit_add),
        .accum_we  (reg_wr_en && hit_acc),
        .wdata     (reg_wdata),
        .addend    (addend),
        .accum     (accum),
        .tick      (tick)
    );

    ptp_time_core #(.WORD_W(DATA_W)) i_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (st_q.hold),
        .tick      (tick),
        .lo_we     (reg_wr_en && hit_tlo),
        .hi_we     (reg_wr_en && hit_thi),
        .lo_rd     (reg_rd_en && hit_tlo),
        .wdata     (reg_wdata),
        .sys_time  (sys_time),
        .hi_shadow (hi_shadow)
    );

    ptp_target_cmp #(.WORD_W(DATA_W)) i_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_time (sys_time),
        .enable   (st_q.tgt_en),
        .lo_we    (reg_wr_en && hit_glo),
        .hi_we    (reg_wr_en && hit_ghi),
        .clr      (reg_wr_en && hit_evt && reg_wdata[EVT_TGT_BIT]),
        .wdata    (reg_wdata),
        .target   (target),
        .pending  (pending)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = reg_rd_en;
        if (reg_wr_en && hit_ctrl) begin
            st_d.hold   = reg_wdata[CTRL_HOLD_BIT];
            st_d.tgt_en = reg_wdata[CTRL_TGT_EN_BIT];
        end
        if (reg_rd_en) begin
            st_d.rdata = '0;
            unique case (1'b1)
                hit_ctrl: begin
                    st_d.rdata[CTRL_HOLD_BIT]   = st_q.hold;
                    st_d.rdata[CTRL_TGT_EN_BIT] = st_q.tgt_en;
                end
                hit_evt:  st_d.rdata[EVT_TGT_BIT] = pending;
                hit_add:  st_d.rdata = addend;
                hit_acc:  st_d.rdata = accum;
                hit_tlo:  st_d.rdata = sys_time[DATA_W-1:0];
                hit_thi:  st_d.rdata = hi_shadow;
                hit_glo:  st_d.rdata = target[DATA_W-1:0];
                hit_ghi:  st_d.rdata = target[TIME_W-1:DATA_W];
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata       = st_q.rdata;
    assign reg_rdata_valid = st_q.rvalid;
    assign tgt_pending     = pending;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> reg_rdata_valid) // R9
        else $error("read data not valid after strobe");
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> !reg_rdata_valid) // R9
        else $error("spurious read valid");
endmodule

// File: tb/test_ptp_sys_timer.sv
module test_ptp_sys_timer;
    import ptp_tc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rdata_valid;
    logic        tgt_pending;

    int unsigned cyc = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptp_sys_timer i_ptp_sys_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_en       (reg_wr_en),
        .reg_rd_en       (reg_rd_en),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .reg_rdata_valid (reg_rdata_valid),
        .tgt_pending     (tgt_pending)
    );

    // monitor: pops expected items as read data appears
    always @(negedge clk) begin
        if (reg_rdata_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_errors++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    // read time low or accumulator; expectation from running-edge count
    task automatic rd_model(input logic [7:0] a, input logic [31:0] rate,
                            input int unsigned e0, input string t);
        logic [63:0] prod;
        int unsigned k;
        @(negedge clk);
        k = cyc - e0;              // read lands on edge cyc+1, sees state after edge cyc
        prod = 64'(k) * 64'(rate);
        reg_rd_en = 1'b1; reg_addr = a;
        exp_q.push_back(a == OFS_ACCUM ? prod[31:0] : prod[63:32] == 0 ? prod[63:32] + 32'(prod >> 32) : 32'(prod >> 32));
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic check_pin(input logic e, input string t);
        @(negedge clk);
        n_checks++;
        if (tgt_pending !== e) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", t, tgt_pending, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned e0, w1, w2;
        logic [63:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(OFS_CTRL,   32'h0,        "R1 control reset");
        rd(OFS_ADDEND, 32'hF0000029, "R1 rate word reset");
        rd(OFS_EVENT,  32'h0,        "R1 event reset");
        check_pin(1'b0, "R1 pending pin reset");

        // R3 hold
        wr(OFS_CTRL, 32'h1);
        idle(3);
        rd(OFS_CTRL,    32'h1, "R9 control readback hold");
        rd(OFS_TIME_LO, 32'h0, "R3 time held at zero");
        rd(OFS_ACCUM,   32'h0, "R3 accumulator held at zero");

        // R2 default rate word
        wr(OFS_CTRL, 32'h0); e0 = cyc;
        idle(4);
        rd_model(OFS_TIME_LO, 32'hF0000029, e0, "R2 time at default rate");
        rd_model(OFS_ACCUM,   32'hF0000029, e0, "R2 accumulator at default rate");
        idle(7);
        rd_model(OFS_TIME_LO, 32'hF0000029, e0, "R2 time at default rate later");

        // R2 quarter rate
        wr(OFS_CTRL, 32'h1);
        wr(OFS_ADDEND, 32'h40000000);
        wr(OFS_CTRL, 32'h0); e0 = cyc;
        idle(9);
        rd_model(OFS_TIME_LO, 32'h40000000, e0, "R2 time at quarter rate");
        rd_model(OFS_ACCUM,   32'h40000000, e0, "R2 accumulator at quarter rate");

        // R10 accumulator load, frozen rate
        wr(OFS_ADDEND, 32'h0);
        wr(OFS_ACCUM, 32'h13572468);
        idle(2);
        rd(OFS_ACCUM, 32'h13572468, "R10 accumulator load");
        wr(OFS_ACCUM, 32'h0);

        // R5 staged low, committed by high
        wr(OFS_CTRL, 32'h1);
        wr(OFS_CTRL, 32'h0);
        wr(OFS_TIME_LO, 32'hFFFFFFFF);
        idle(2);
        rd(OFS_TIME_LO, 32'h0, "R5 low write alone has no effect");
        wr(OFS_TIME_HI, 32'h5);
        rd(OFS_TIME_LO, 32'hFFFFFFFF, "R5 committed low word");
        rd(OFS_TIME_HI, 32'h5,        "R5 committed high word");

        // R4 captured high word
        rd(OFS_TIME_LO, 32'hFFFFFFFF, "R4 low read before carry");
        wr(OFS_ADDEND, 32'h80000000); w1 = cyc;
        idle(10);
        wr(OFS_ADDEND, 32'h0); w2 = cyc;
        rd(OFS_TIME_HI, 32'h5, "R4 high read returns captured word");
        t = 64'h5_FFFFFFFF + 64'((w2 - w1) / 2);
        rd(OFS_TIME_LO, t[31:0],  "R4 live low word");
        rd(OFS_TIME_HI, t[63:32], "R4 coherent high word after new low read");

        // R6 target compare
        wr(OFS_TGT_LO, t[31:0] + 32'h1);
        wr(OFS_TGT_HI, t[63:32]);
        wr(OFS_CTRL, 32'h2);
        idle(4);
        check_pin(1'b0, "R6 below target not pending");
        rd(OFS_EVENT, 32'h0, "R6 event below target");
        rd(OFS_TGT_LO, t[31:0] + 32'h1, "R9 target low readback");
        rd(OFS_TGT_HI, t[63:32],        "R9 target high readback");
        wr(OFS_TGT_LO, t[31:0]);
        idle(3);
        check_pin(1'b1, "R6 equal to target pending");
        rd(OFS_EVENT, 32'h2, "R6 event bit 1 set");

        // R7 clear semantics
        wr(OFS_EVENT, 32'h0);
        idle(2);
        check_pin(1'b1, "R7 write 0 leaves flag");
        wr(OFS_EVENT, 32'h2);
        idle(2);
        check_pin(1'b1, "R7 set wins while condition holds");
        wr(OFS_CTRL, 32'h0);
        wr(OFS_EVENT, 32'h2);
        idle(1);
        check_pin(1'b0, "R7 write 1 clears");
        rd(OFS_EVENT, 32'h0, "R7 event cleared");

        // R8 disabled stays quiet
        idle(6);
        check_pin(1'b0, "R8 disabled no set");
        rd(OFS_CTRL, 32'h0, "R9 control readback cleared");

        // R6 greater than target
        wr(OFS_TGT_HI, t[63:32] - 32'h1);
        wr(OFS_CTRL, 32'h2);
        idle(3);
        check_pin(1'b1, "R6 above target pending");

        idle(3);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R9 reads missing: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule